// File: doc/BRIEF.md
# AHB Read Burst Planner

This block turns one read request into a train of AHB address phases. A request names a starting word address and a length counted in 32-bit words. For each burst the planner chooses the HBURST encoding and the beat count from a maximum-length policy and a precise-burst mode. It drives the address and control signals of a simplified AHB master and follows the data phases. When the last data phase completes it raises a one-cycle completion pulse.

The policy input takes five legal values. With 0, the whole request goes out as one undefined-length INCR burst. With 1, every beat is a SINGLE. With 4, 8 or 16, bursts are capped at INCR4, INCR8 or INCR16, and INCR or SINGLE transfers finish the tail. In precise mode a short tail is over-fetched as a fixed INCR4. The surplus beats are then flagged as discard rather than delivered. An optional lock keeps HLOCK asserted together with the bus request.

Top module: `ahb_burst_planner`

## Requirements
- R1: After reset, and whenever no request is active, `req_ready` is 1, `htrans` is IDLE (2'b00), `hbusreq` and `hlock` are 0 and `done` is 0.
- R2: Policy value 0 issues the whole request as one burst with `hburst` = INCR (3'b001). Its first beat is NONSEQ (2'b10) and every later beat is SEQ (2'b11).
- R3: Policy value 1, and every value outside {0,1,4,8,16}, issues each beat as `hburst` = SINGLE (3'b000) with `htrans` NONSEQ.
- R4: With policy 4, 8 or 16, each burst takes the largest of 16, 8 and 4 that fits both the policy and the words still to issue, encoded INCR4 = 3'b011, INCR8 = 3'b101, INCR16 = 3'b111. A remaining single word goes out as SINGLE.
- R5: With policy 4, 8 or 16 and precise mode off, a remainder of 2 or 3 words goes out as one INCR burst of exactly that many beats.
- R6: With policy 4, 8 or 16 and precise mode on, INCR is never used. A remainder of 2 or 3 words is read as INCR4, and the beats past the requested length complete on `beat_discard` instead of `beat_ok`.
- R7: `haddr` is the byte address 4*(start word + number of address phases already accepted in the request), and this includes over-fetched beats.
- R8: `hbusreq` is 1 from the cycle after acceptance up to and including the cycle in which the final address phase is accepted. `hlock` equals `hbusreq` AND the latched lock bit. `htrans` is IDLE while `hgrant` is 0.
- R9: While `hready` is 0, `htrans`, `hburst` and `haddr` hold their values. `beat_cnt` advances by one only after a cycle with `beat_ok` high.
- R10: `done` is high for exactly one cycle, the cycle after the final data phase completes. In that cycle `req_ready` is 1 and `beat_cnt` equals the requested length.
- R11: Policy, precise and lock inputs are sampled only when a request is accepted. Changing them during a request has no effect on that request.
- R12: A request with length 0 is ignored: the block stays idle and requests no bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Length in words |
| cfg_max_len | input | 5 | Maximum-burst policy (0,1,4,8,16) |
| cfg_precise | input | 1 | Fixed bursts only, discard surplus |
| cfg_lock | input | 1 | Assert HLOCK with the bus request |
| hgrant | input | 1 | Bus granted to this master |
| hready | input | 1 | Transfer ready |
| hbusreq | output | 1 | Bus request |
| hlock | output | 1 | Locked transfer request |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| haddr | output | ADDR_W+2 | Byte address |
| beat_ok | output | 1 | Useful data phase completed |
| beat_discard | output | 1 | Surplus data phase completed |
| beat_cnt | output | LEN_W | Useful beats completed in this request |
| done | output | 1 | Request complete pulse |

## Verification
Two functions share one cycle when a burst ends. The data phase of one burst's last beat completes in the same cycle that the next burst's NONSEQ address phase is presented, or the final discard beat completes while the bus request drops. The bench provokes both by sweeping every policy and precise setting over lengths 1 to 20. It runs each sweep once with occasional `hready` stalls and once with stalls on about half the cycles, so stalls land on both the boundary address and the boundary data phase. Each accepted address phase is checked against an arithmetic model of the burst split. Useful and discarded beats are tallied separately, and the completion pulse is required exactly one cycle after the tally reaches the planned beat total.

// File: rtl/ahb_plan_pkg.sv
package ahb_plan_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic [2:0] {
        HB_SINGLE = 3'b000,
        HB_INCR   = 3'b001,
        HB_INCR4  = 3'b011,
        HB_INCR8  = 3'b101,
        HB_INCR16 = 3'b111
    } hburst_e;

    typedef enum logic [2:0] {
        MP_UNDEF,
        MP_SINGLE,
        MP_CAP4,
        MP_CAP8,
        MP_CAP16
    } maxpol_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARB,
        SQ_XFER,
        SQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic discard;
        logic last;
    } dphase_t;

    localparam int CFG_W = 5;

    function automatic maxpol_e decode_max(input logic [CFG_W-1:0] v);
        case (v)
            5'd0:    return MP_UNDEF;
            5'd4:    return MP_CAP4;
            5'd8:    return MP_CAP8;
            5'd16:   return MP_CAP16;
            default: return MP_SINGLE;
        endcase
    endfunction

    function automatic logic is_capped(input maxpol_e p);
        return (p == MP_CAP4) || (p == MP_CAP8) || (p == MP_CAP16);
    endfunction

endpackage

// File: rtl/burst_select.sv
module burst_select
    import ahb_plan_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  maxpol_e          pol,
    input  logic             precise,
    input  logic [LEN_W-1:0] rem,
    output hburst_e          kind,
    output logic [LEN_W-1:0] beats,
    output logic [LEN_W-1:0] useful
);
    localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] FOUR = LEN_W'(4);
    localparam logic [LEN_W-1:0] EGHT = LEN_W'(8);
    localparam logic [LEN_W-1:0] SXTN = LEN_W'(16);

    logic [LEN_W-1:0] cap;
    logic [LEN_W-1:0] fit;

    always_comb begin
        case (pol)
            MP_CAP4:  cap = FOUR;
            MP_CAP8:  cap = EGHT;
            MP_CAP16: cap = SXTN;
            default:  cap = ONE;
        endcase
        fit = (rem < cap) ? rem : cap;
    end

    always_comb begin
        kind   = HB_SINGLE;
        beats  = ONE;
        useful = ONE;
        case (pol)
            MP_UNDEF: begin
                kind   = HB_INCR;
                beats  = rem;
                useful = rem;
            end
            MP_SINGLE: begin
                kind   = HB_SINGLE;
                beats  = ONE;
                useful = ONE;
            end
            default: begin
                if (fit >= SXTN) begin
                    kind = HB_INCR16; beats = SXTN; useful = SXTN;
                end else if (fit >= EGHT) begin
                    kind = HB_INCR8; beats = EGHT; useful = EGHT;
                end else if (fit >= FOUR) begin
                    kind = HB_INCR4; beats = FOUR; useful = FOUR;
                end else if (rem >= TWO) begin
                    if (precise) begin
                        kind = HB_INCR4; beats = FOUR; useful = rem;
                    end else begin
                        kind = HB_INCR; beats = rem; useful = rem;
                    end
                end else begin
                    kind = HB_SINGLE; beats = ONE; useful = ONE;
                end
            end
        endcase
    end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import ahb_plan_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [CFG_W-1:0]    cfg_max_len,
    input  logic                cfg_precise,
    input  logic                cfg_lock,
    input  logic                hgrant,
    input  logic                hready,
    input  logic                data_done,
    output logic                req_ready,
    output logic                req_take,
    output htrans_e             htrans,
    output hburst_e             hburst,
    output logic [ADDR_W+1:0]   haddr,
    output logic                hbusreq,
    output logic                hlock,
    output logic                ap_accept,
    output logic                ap_discard,
    output logic                ap_last
);
    localparam int HA_W = ADDR_W + 2;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  idx_q;
    maxpol_e           pol_q;
    logic              prec_q;
    logic              lock_q;

    hburst_e           sel_kind;
    logic [LEN_W-1:0]  sel_beats;
    logic [LEN_W-1:0]  sel_useful;
    logic              drive;
    logic              burst_end;

    burst_select #(.LEN_W(LEN_W)) u_sel (
        .pol     (pol_q),
        .precise (prec_q),
        .rem     (rem_q),
        .kind    (sel_kind),
        .beats   (sel_beats),
        .useful  (sel_useful)
    );

    always_comb begin
        req_ready  = (state_q == SQ_IDLE);
        req_take   = req_ready && req_valid && (req_len != '0);
        drive      = (state_q == SQ_XFER) && hgrant;
        htrans     = drive ? ((idx_q == '0) ? TR_NONSEQ : TR_SEQ) : TR_IDLE;
        hburst     = drive ? sel_kind : HB_SINGLE;
        haddr      = {addr_q, 2'b00};
        hbusreq    = (state_q == SQ_ARB) || (state_q == SQ_XFER);
        hlock      = hbusreq && lock_q;
        burst_end  = (idx_q == sel_beats - LEN_W'(1));
        ap_accept  = drive && hready;
        ap_discard = (idx_q >= sel_useful);
        ap_last    = burst_end && (rem_q == sel_useful);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            pol_q   <= MP_SINGLE;
            prec_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (req_take) begin
                        addr_q  <= req_addr;
                        rem_q   <= req_len;
                        idx_q   <= '0;
                        pol_q   <= decode_max(cfg_max_len);
                        prec_q  <= cfg_precise;
                        lock_q  <= cfg_lock;
                        state_q <= SQ_ARB;
                    end
                end
                SQ_ARB: begin
                    if (hgrant) state_q <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (ap_accept) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        if (burst_end) begin
                            idx_q <= '0;
                            rem_q <= rem_q - sel_useful;
                            if (ap_last) state_q <= SQ_DRAIN;
                        end else begin
                            idx_q <= idx_q + LEN_W'(1);
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (data_done) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans[1] && !hready && hgrant) |=>
            (!hgrant || ($stable(haddr) && $stable(htrans) && $stable(hburst))));

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans[1] && hready) |=>
            (htrans != TR_SEQ || haddr == $past(haddr) + HA_W'(4)));

    // R6
    precise_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (prec_q && is_capped(pol_q) && htrans[1]) |-> (hburst != HB_INCR));

    // R3
    single_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (pol_q == MP_SINGLE && htrans[1]) |-> (hburst == HB_SINGLE && htrans == TR_NONSEQ));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && $past(state_q) != SQ_IDLE) |->
            ($stable(pol_q) && $stable(prec_q) && $stable(lock_q)));

endmodule

// File: rtl/beat_tracker.sv
module beat_tracker
    import ahb_plan_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hready,
    input  logic             start,
    input  logic             ap_accept,
    input  logic             ap_discard,
    input  logic             ap_last,
    output logic             beat_ok,
    output logic             beat_discard,
    output logic [LEN_W-1:0] beat_cnt,
    output logic             data_done,
    output logic             done
);
    dphase_t          dp_q;
    logic             complete;
    logic [LEN_W-1:0] cnt_q;
    logic             done_q;

    always_comb begin
        complete     = dp_q.valid && hready;
        beat_ok      = complete && !dp_q.discard;
        beat_discard = complete && dp_q.discard;
        data_done    = complete && dp_q.last;
        beat_cnt     = cnt_q;
        done         = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (hready) begin
                dp_q.valid   <= ap_accept;
                dp_q.discard <= ap_accept && ap_discard;
                dp_q.last    <= ap_accept && ap_last;
            end
            if (start)        cnt_q <= '0;
            else if (beat_ok) cnt_q <= cnt_q + LEN_W'(1);
            done_q <= data_done;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!beat_ok && !start) |=> $stable(beat_cnt));

    // R9
    stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!hready && (beat_ok || beat_discard)) |-> 1'b0);

endmodule

// File: rtl/ahb_burst_planner.sv
module ahb_burst_planner
    import ahb_plan_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [4:0]        cfg_max_len,
    input  logic              cfg_precise,
    input  logic              cfg_lock,
    input  logic              hgrant,
    input  logic              hready,
    output logic              hbusreq,
    output logic              hlock,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [ADDR_W+1:0] haddr,
    output logic              beat_ok,
    output logic              beat_discard,
    output logic [LEN_W-1:0]  beat_cnt,
    output logic              done
);
    htrans_e trans_w;
    hburst_e burst_w;
    logic    take_w;
    logic    acc_w;
    logic    disc_w;
    logic    last_w;
    logic    ddone_w;

    xfer_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .cfg_max_len (cfg_max_len),
        .cfg_precise (cfg_precise),
        .cfg_lock    (cfg_lock),
        .hgrant      (hgrant),
        .hready      (hready),
        .data_done   (ddone_w),
        .req_ready   (req_ready),
        .req_take    (take_w),
        .htrans      (trans_w),
        .hburst      (burst_w),
        .haddr       (haddr),
        .hbusreq     (hbusreq),
        .hlock       (hlock),
        .ap_accept   (acc_w),
        .ap_discard  (disc_w),
        .ap_last     (last_w)
    );

    beat_tracker #(.LEN_W(LEN_W)) u_trk (
        .clk          (clk),
        .rst          (rst),
        .hready       (hready),
        .start        (take_w),
        .ap_accept    (acc_w),
        .ap_discard   (disc_w),
        .ap_last      (last_w),
        .beat_ok      (beat_ok),
        .beat_discard (beat_discard),
        .beat_cnt     (beat_cnt),
        .data_done    (ddone_w),
        .done         (done)
    );

    assign htrans = trans_w;
    assign hburst = burst_w;

endmodule

// File: tb/ahb_burst_planner_tb.sv
`timescale 1ns/1ps
module ahb_burst_planner_tb_top;
    localparam int ADDR_W = 30;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [4:0]        cfg_max_len = '0;
    logic              cfg_precise = 1'b0;
    logic              cfg_lock = 1'b0;
    logic              hgrant = 1'b0;
    logic              hready = 1'b1;
    logic              hbusreq, hlock, beat_ok, beat_discard, done;
    logic [1:0]        htrans;
    logic [2:0]        hburst;
    logic [ADDR_W+1:0] haddr;
    logic [LEN_W-1:0]  beat_cnt;

    int tests = 0;
    int fails = 0;

    ahb_burst_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_max_len(cfg_max_len),
        .cfg_precise(cfg_precise), .cfg_lock(cfg_lock), .hgrant(hgrant),
        .hready(hready), .hbusreq(hbusreq), .hlock(hlock), .htrans(htrans),
        .hburst(hburst), .haddr(haddr), .beat_ok(beat_ok),
        .beat_discard(beat_discard), .beat_cnt(beat_cnt), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // burst plan model: kind code, beats, useful words
    function automatic void plan(input int mx, input bit pr, input int rem,
                                 output int kind, output int beats, output int useful);
        int f;
        if (mx == 0) begin
            kind = 1; beats = rem; useful = rem;
        end else if (mx != 4 && mx != 8 && mx != 16) begin
            kind = 0; beats = 1; useful = 1;
        end else begin
            f = 16;
            while (f > mx || f > rem) f = f / 2;
            if (f >= 4) begin
                kind = (f == 4) ? 3 : (f == 8) ? 5 : 7; beats = f; useful = f;
            end else if (rem >= 2) begin
                if (pr) begin kind = 3; beats = 4; useful = rem; end
                else    begin kind = 1; beats = rem; useful = rem; end
            end else begin
                kind = 0; beats = 1; useful = 1;
            end
        end
    endfunction

    function automatic string tag_of(input int mx, input bit pr, input int rem);
        if (mx == 0) return "R2";
        if (mx != 4 && mx != 8 && mx != 16) return "R3";
        if (rem == 2 || rem == 3) return pr ? "R6" : "R5";
        return "R4";
    endfunction

    // model state
    bit                active = 0;
    bit                done_seen = 0;
    bit                expect_done = 0;
    int                m_max, m_len, m_rem, m_idx, m_total, m_disc;
    bit                m_prec, m_lock;
    logic [ADDR_W-1:0] m_addr;
    int                got_ok, got_disc;
    bit                stall_heavy = 0;
    logic [15:0]       lfsr = 16'hACE1;

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hready = stall_heavy ? lfsr[0] : (lfsr[2:0] != 3'b000);
    end

    bit          prv_stall = 0;
    logic [1:0]  prv_tr;
    logic [2:0]  prv_hb;
    logic [ADDR_W+1:0] prv_ad;

    always @(negedge clk) begin
        if (!rst) begin
            if (expect_done) begin
                // R10
                check(done === 1'b1, "R10", "done after last beat", done, 1);
                check(req_ready === 1'b1, "R10", "ready with done", req_ready, 1);
                check(beat_cnt == LEN_W'(m_len), "R10", "beat_cnt at done", beat_cnt, m_len);
                check(got_disc == m_disc, "R6", "discard beats", got_disc, m_disc);
                expect_done = 0; active = 0; done_seen = 1;
            end else if (done) begin
                check(1'b0, "R10", "spurious done", 1, 0);
            end
        end
        if (active) begin
            // R8
            check(hbusreq === (m_rem > 0), "R8", "hbusreq", hbusreq, m_rem > 0);
            check(hlock === (hbusreq && m_lock), "R8", "hlock", hlock, hbusreq && m_lock);
            if (!hgrant) check(htrans == 2'b00, "R8", "idle without grant", htrans, 0);
            // R9
            check(beat_cnt == LEN_W'(got_ok), "R9", "beat_cnt", beat_cnt, got_ok);
            if (prv_stall)
                check(htrans == prv_tr && hburst == prv_hb && haddr == prv_ad,
                      "R9", "hold under stall", haddr, prv_ad);
            prv_stall = htrans[1] && !hready;
            prv_tr = htrans; prv_hb = hburst; prv_ad = haddr;
            if (htrans[1] && hready) begin
                int k, b, u;
                plan(m_max, m_prec, m_rem, k, b, u);
                check(hburst == 3'(k), tag_of(m_max, m_prec, m_rem), "hburst", hburst, k);
                check(htrans == ((m_idx == 0) ? 2'b10 : 2'b11),
                      tag_of(m_max, m_prec, m_rem), "htrans", htrans, (m_idx == 0) ? 2 : 3);
                // R7
                check(haddr == {m_addr, 2'b00}, "R7", "haddr", haddr, {m_addr, 2'b00});
                m_addr = m_addr + 1'b1;
                m_idx++;
                if (m_idx == b) begin m_idx = 0; m_rem -= u; end
            end
            if (beat_ok) got_ok++;
            if (beat_discard) got_disc++;
            if ((beat_ok || beat_discard) && (got_ok + got_disc == m_total))
                expect_done = 1;
        end
    end

    task automatic run_req(input int mx, input bit pr, input bit lk,
                           input int addr, input int len, input int gdly);
        int r, k, b, u, wait_cyc;
        m_max = mx; m_prec = pr; m_lock = lk; m_len = len; m_rem = len;
        m_idx = 0; m_addr = ADDR_W'(addr); got_ok = 0; got_disc = 0;
        m_total = 0; m_disc = 0; r = len;
        while (r > 0) begin
            plan(mx, pr, r, k, b, u);
            m_total += b; m_disc += b - u; r -= u;
        end
        req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
        cfg_max_len = 5'(mx); cfg_precise = pr; cfg_lock = lk;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        // R11: scramble configuration after acceptance
        cfg_max_len = 5'(mx) ^ 5'h1f; cfg_precise = ~pr; cfg_lock = ~lk;
        done_seen = 0; prv_stall = 0; active = 1;
        repeat (gdly) @(posedge clk);
        #1 hgrant = 1'b1;
        wait_cyc = 0;
        while (!done_seen && wait_cyc < 3000) begin @(posedge clk); wait_cyc++; end
        if (!done_seen) begin
            check(1'b0, "R10", "request never completed", 0, 1);
            active = 0; expect_done = 0;
        end
        #1 hgrant = 1'b0;
    endtask

    bit wd_fired = 0;
    initial begin
        #(4 * 190000);
        wd_fired = 1;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int mxs[6];
        mxs = '{0, 1, 2, 4, 8, 16};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(htrans == 2'b00, "R1", "htrans after reset", htrans, 0);
        check(hbusreq === 1'b0 && hlock === 1'b0, "R1", "bus request after reset", hbusreq, 0);
        check(done === 1'b0, "R1", "done after reset", done, 0);
        // R12: zero length ignored
        @(posedge clk); #1;
        req_len = '0; req_valid = 1'b1; cfg_max_len = 5'd8;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(req_ready === 1'b1 && hbusreq === 1'b0 && htrans == 2'b00,
                  "R12", "zero length stays idle", hbusreq, 0);
        end
        @(posedge clk); #1 req_valid = 1'b0;
        for (int s = 0; s < 2; s++) begin
            stall_heavy = s[0];
            for (int mi = 0; mi < 6; mi++)
                for (int p = 0; p < 2; p++)
                    for (int len = 1; len <= 20; len++)
                        run_req(mxs[mi], p[0], len[0], 32'h100 + len * 37, len, len % 4);
        end
        run_req(0, 1'b0, 1'b1, 32'h4000, 40, 1);
        run_req(16, 1'b1, 1'b0, 32'h5000, 51, 0);
        repeat (4) @(negedge clk);
        // R1: idle again after traffic
        check(req_ready === 1'b1 && htrans == 2'b00 && hbusreq === 1'b0,
              "R1", "idle after run", htrans, 0);
        if (!wd_fired) begin
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule